// File: doc/BRIEF.md
# Windowed Scratchpad Register File

This block is a small on-chip register file of 64 byte-wide cells, reached either by a short direct address taken from an instruction field or through a six-bit index register. The direct field is four bits wide, so only cells 0 to 15 can be named that way. Every other cell is reached by first loading the index register and then issuing an indirect access.

An indirect access can leave the index where it is, step it up by one, or step it down by one once the access is done. A step changes only the low three bits of the index, so the pointer cycles around the eight-cell group it is in and never leaves it. Loading a new index value moves the working group. The old group keeps its contents, so a routine can take a fresh set of registers with one load and restore the old set later with another.

Reads are combinational from the selected cell. Writes and index changes take place on the rising clock edge. A synchronous reset clears the index register but leaves the cell contents alone. A three-bit operation code from the surrounding decode logic selects what happens in each cycle.

Top module: `spw_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, the index register becomes 0 after that edge, and `idx_o` shows 0.
- R2: Op code 1 (direct) reads cell `dir_addr_i` (0 to 15) on `rdata_o`. If `we_i` is high, it writes `wdata_i` into that cell at the edge. The index register is not changed.
- R3: Op code 2 (indirect) reads the cell addressed by the index register. If `we_i` is high, it writes `wdata_i` into that cell. The index register is not changed.
- R4: Op code 3 (indirect, step up) accesses the cell like R3. After the edge, the low three index bits are one higher modulo 8 (7 goes to 0) and the upper three bits are unchanged.
- R5: Op code 4 (indirect, step down) accesses the cell like R3. After the edge, the low three index bits are one lower modulo 8 (0 goes to 7) and the upper three bits are unchanged.
- R6: Op code 5 (load index) places `wdata_i[5:0]` in the index register at the edge, writes no cell, and drives `rdata_o` to 0.
- R7: Op code 6 (read index) drives `rdata_o` with the index value zero-extended to 8 bits. It changes neither the index nor any cell.
- R8: Op code 0 (idle) and the unused code 7 drive `rdata_o` to 0 and change nothing. An access op with `we_i` low writes no cell.
- R9: Cells in a group keep their values while the index points at another group, and they read back unchanged when the index returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates take place on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the index register |
| op_i | input | 3 | Operation code: 0 idle, 1 direct, 2 indirect, 3 indirect step up, 4 indirect step down, 5 load index, 6 read index |
| dir_addr_i | input | 4 | Direct cell address used by op code 1 |
| wdata_i | input | 8 | Write data for cell writes; bits 5:0 are the new index for op code 5 |
| we_i | input | 1 | Write enable for op codes 1 to 4 |
| rdata_o | output | 8 | Combinational read data |
| idx_o | output | 6 | Current index register value |

## Verification
The bench builds the block with its default parameters: 64 cells, eight-cell groups, a four-bit direct field and 8-bit data. These values put every group boundary within reach of a short directed sequence. They allow wrap-around in both directions at the top and bottom of the pointer range, direct access up to the last directly named cell while the index sits in a high group, and a full save-and-restore round trip across two groups. A reference model in the bench tracks all 64 cells and the index, and each read and each index value is compared against it.

// File: rtl/spw_pkg.sv
package spw_pkg;

  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_DIRECT   = 3'd1,
    OP_IND      = 3'd2,
    OP_IND_UP   = 3'd3,
    OP_IND_DN   = 3'd4,
    OP_LOAD_IDX = 3'd5,
    OP_READ_IDX = 3'd6
  } spw_op_e;

  function automatic logic op_is_access(input spw_op_e op);
    return (op == OP_DIRECT) || (op == OP_IND) ||
           (op == OP_IND_UP) || (op == OP_IND_DN);
  endfunction

  function automatic logic op_is_indirect(input spw_op_e op);
    return (op == OP_IND) || (op == OP_IND_UP) || (op == OP_IND_DN);
  endfunction

endpackage

// File: rtl/spw_addr_sel.sv
module spw_addr_sel
  import spw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WIN_W  = 3,
  parameter int DIR_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  spw_op_e           op,
  input  logic [DIR_W-1:0]  dir_addr,
  input  logic [ADDR_W-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] cell_addr,
  output logic              access,
  output logic              idx_upd,
  output logic [ADDR_W-1:0] idx_nxt
);

  localparam int PAD_W = ADDR_W - DIR_W;

  // Step the pointer inside its group: only the low WIN_W bits move.
  function automatic logic [ADDR_W-1:0] win_step(input logic [ADDR_W-1:0] p,
                                                 input logic up);
    logic [WIN_W-1:0] lo;
    lo = up ? (p[WIN_W-1:0] + WIN_W'(1)) : (p[WIN_W-1:0] - WIN_W'(1));
    return {p[ADDR_W-1:WIN_W], lo};
  endfunction

  function automatic logic [ADDR_W-1:0] widen_dir(input logic [DIR_W-1:0] a);
    return {{PAD_W{1'b0}}, a};
  endfunction

  assign access = op_is_access(op);

  always_comb begin
    if (op_is_indirect(op)) cell_addr = idx;
    else                    cell_addr = widen_dir(dir_addr);
  end

  always_comb begin
    idx_upd = 1'b1;
    idx_nxt = idx;
    case (op)
      OP_IND_UP:   idx_nxt = win_step(idx, 1'b1);
      OP_IND_DN:   idx_nxt = win_step(idx, 1'b0);
      OP_LOAD_IDX: idx_nxt = wdata[ADDR_W-1:0];
      default:     idx_upd = 1'b0;
    endcase
  end

  // R2: a direct access never reaches beyond the directly named range
  a_r2_direct_low: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DIRECT) |-> (cell_addr < ADDR_W'(1 << DIR_W)));

endmodule

// File: rtl/spw_index_reg.sv
module spw_index_reg #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [ADDR_W-1:0] nxt,
  output logic [ADDR_W-1:0] idx_q
);

  always_ff @(posedge clk) begin
    if (rst)      idx_q <= '0;
    else if (upd) idx_q <= nxt;
  end

  // R1: reset leaves the pointer at cell zero
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (idx_q == '0));

endmodule

// File: rtl/spw_store.sv
module spw_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wr_data;
  end

  assign rd_data = cells[addr];

endmodule

// File: rtl/spw_regfile.sv
module spw_regfile
  import spw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WIN_W  = 3,
  parameter int DIR_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic [DIR_W-1:0]  dir_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] idx_o
);

  localparam int EXT_W = DATA_W - ADDR_W;

  spw_op_e           op;
  logic [ADDR_W-1:0] cell_addr;
  logic              access;
  logic              idx_upd;
  logic [ADDR_W-1:0] idx_nxt;
  logic              wr_en;
  logic [DATA_W-1:0] cell_rd;

  assign op    = spw_op_e'(op_i);
  assign wr_en = access && we_i;

  spw_addr_sel #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .DIR_W(DIR_W), .DATA_W(DATA_W)
  ) sel_i (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .dir_addr  (dir_addr_i),
    .idx       (idx_o),
    .wdata     (wdata_i),
    .cell_addr (cell_addr),
    .access    (access),
    .idx_upd   (idx_upd),
    .idx_nxt   (idx_nxt)
  );

  spw_index_reg #(.ADDR_W(ADDR_W)) idx_i (
    .clk   (clk),
    .rst   (rst),
    .upd   (idx_upd),
    .nxt   (idx_nxt),
    .idx_q (idx_o)
  );

  spw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .addr    (cell_addr),
    .wr_data (wdata_i),
    .rd_data (cell_rd)
  );

  always_comb begin
    if (op == OP_READ_IDX) rdata_o = {{EXT_W{1'b0}}, idx_o};
    else if (access)       rdata_o = cell_rd;
    else                   rdata_o = '0;
  end

  // R3: plain accesses, idle and index reads leave the pointer alone
  a_r3_idx_hold: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd0 || op_i == 3'd1 || op_i == 3'd2 || op_i == 3'd6 || op_i == 3'd7)
    |=> $stable(idx_o));

  // R4: step up wraps within the group
  a_r4_up_wraps: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd3) |=>
      (idx_o[ADDR_W-1:WIN_W] == $past(idx_o[ADDR_W-1:WIN_W])) &&
      (idx_o[WIN_W-1:0] == WIN_W'($past(idx_o[WIN_W-1:0]) + WIN_W'(1))));

  // R5: step down wraps within the group
  a_r5_dn_wraps: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd4) |=>
      (idx_o[ADDR_W-1:WIN_W] == $past(idx_o[ADDR_W-1:WIN_W])) &&
      (idx_o[WIN_W-1:0] == WIN_W'($past(idx_o[WIN_W-1:0]) - WIN_W'(1))));

  // R6: loading the index takes the low data bits
  a_r6_load_idx: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd5) |=> (idx_o == $past(wdata_i[ADDR_W-1:0])));

  // R8: no cell write without the enable
  a_r8_no_write: assert property (@(posedge clk) disable iff (rst)
    !we_i |-> !wr_en);

endmodule

// File: tb/spw_regfile_tb.sv
module spw_regfile_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_i = 3'd0;
  logic [3:0] dir_addr_i = 4'd0;
  logic [7:0] wdata_i = 8'd0;
  logic       we_i = 1'b0;
  logic [7:0] rdata_o;
  logic [5:0] idx_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int model [64];
  bit known [64];
  int idx_m = 0;

  always #5 clk = ~clk;

  spw_regfile dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .dir_addr_i(dir_addr_i),
    .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o), .idx_o(idx_o)
  );

  function automatic int pat(input int a, input int salt);
    return (a * 37 + 11 + salt) % 256;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one operation, check the combinational read, then the index after the edge.
  task automatic do_op(input int op, input int da, input int wd, input bit w,
                       input string tag);
    int exp_r;
    bit chk;
    int tgt;
    @(negedge clk);
    op_i = 3'(op); dir_addr_i = 4'(da); wdata_i = 8'(wd); we_i = w;
    #2;
    chk = 0; exp_r = 0; tgt = -1;
    if (op == 1) tgt = da;
    else if (op >= 2 && op <= 4) tgt = idx_m;
    if (tgt >= 0) begin
      if (known[tgt]) begin chk = 1; exp_r = model[tgt]; end
    end else if (op == 6) begin
      chk = 1; exp_r = idx_m;
    end else begin
      chk = 1; exp_r = 0;
    end
    if (chk) check(rdata_o == 8'(exp_r), tag, rdata_o, exp_r);
    @(posedge clk); #1;
    if (tgt >= 0 && w) begin model[tgt] = wd % 256; known[tgt] = 1; end
    if (op == 3) idx_m = (idx_m / 8) * 8 + (idx_m % 8 + 1) % 8;
    else if (op == 4) idx_m = (idx_m / 8) * 8 + (idx_m % 8 + 7) % 8;
    else if (op == 5) idx_m = wd % 64;
    check(idx_o == 6'(idx_m), tag, idx_o, idx_m);
  endtask

  task automatic t_reset_state;
    check(idx_o == 6'd0, "R1 reset", idx_o, 0);
    do_op(5, 0, 45, 0, "R6 load before reset");
    @(negedge clk); op_i = 3'd0; rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0; idx_m = 0;
    check(idx_o == 6'd0, "R1 mid-run reset", idx_o, 0);
  endtask

  task automatic t_fill_up;
    for (int w = 0; w < 8; w++) begin
      do_op(5, 0, w * 8 + 192, 0, "R6 load group base");
      for (int k = 0; k < 8; k++)
        do_op(3, 0, pat(w * 8 + k, 0), 1, "R4 step up write");
      check(idx_o == 6'(w * 8), "R4 wrap back to base", idx_o, w * 8);
    end
    do_op(5, 0, 8, 0, "R6 load");
    for (int k = 0; k < 9; k++) do_op(3, 0, 0, 0, "R4 step up read");
  endtask

  task automatic t_step_down;
    do_op(5, 0, 16, 0, "R6 load low edge");
    do_op(4, 0, 0, 0, "R5 wrap 0 to 7");
    check(idx_o == 6'd23, "R5 group kept", idx_o, 23);
    for (int k = 0; k < 8; k++) do_op(4, 0, 0, 0, "R5 step down read");
    do_op(5, 0, 63, 0, "R6 load top");
    do_op(3, 0, 0, 0, "R4 wrap at top");
    check(idx_o == 6'd56, "R4 top group", idx_o, 56);
    do_op(4, 0, 0, 0, "R5 back to top");
  endtask

  task automatic t_direct;
    do_op(5, 0, 40, 0, "R6 load high group");
    for (int a = 0; a < 16; a++) do_op(1, a, 0, 0, "R2 direct read");
    do_op(1, 15, 170, 1, "R2 direct write");
    do_op(1, 15, 0, 0, "R2 direct readback");
    do_op(5, 0, 15, 0, "R6 load");
    do_op(2, 0, 0, 0, "R3 indirect sees direct write");
    do_op(2, 0, 85, 1, "R3 indirect write");
    do_op(1, 15, 0, 0, "R2 direct sees indirect write");
    do_op(5, 0, 40, 0, "R6 load");
    do_op(2, 0, 0, 0, "R3 cell 40 untouched");
  endtask

  task automatic t_read_idx;
    do_op(5, 0, 255, 0, "R6 upper data bits dropped");
    do_op(6, 0, 0, 0, "R7 read index 63");
    do_op(5, 0, 21, 0, "R6 load");
    do_op(6, 0, 0, 1, "R7 read index 21");
    do_op(2, 0, 0, 0, "R7 no cell change");
  endtask

  task automatic t_no_write;
    do_op(5, 0, 33, 0, "R6 load");
    do_op(2, 0, 238, 0, "R8 indirect we low");
    do_op(2, 0, 0, 0, "R8 cell unchanged");
    do_op(1, 3, 238, 0, "R8 direct we low");
    do_op(1, 3, 0, 0, "R8 direct cell unchanged");
    do_op(0, 3, 99, 1, "R8 idle");
    do_op(7, 3, 99, 1, "R8 code 7");
    do_op(1, 3, 0, 0, "R8 idle/code 7 wrote nothing");
    do_op(5, 0, 1, 1, "R6 load writes no cell");
    do_op(1, 1, 0, 0, "R6 cell 1 untouched");
  endtask

  task automatic t_window_swap;
    do_op(5, 0, 24, 0, "R9 select group 3");
    for (int k = 0; k < 8; k++) do_op(3, 0, pat(k, 100), 1, "R9 write group 3");
    do_op(5, 0, 48, 0, "R9 select group 6");
    for (int k = 0; k < 8; k++) do_op(3, 0, pat(k, 7), 1, "R9 write group 6");
    do_op(5, 0, 24, 0, "R9 back to group 3");
    for (int k = 0; k < 8; k++) do_op(3, 0, 0, 0, "R9 group 3 intact");
    do_op(5, 0, 48, 0, "R9 back to group 6");
    for (int k = 0; k < 8; k++) do_op(4, 0, 0, 0, "R9 group 6 intact");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin model[i] = 0; known[i] = 0; end
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset_state();
    t_fill_up();
    t_step_down();
    t_direct();
    t_read_idx();
    t_no_write();
    t_window_swap();
    @(negedge clk); op_i = 3'd0; we_i = 1'b0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule